// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block holds the transmit and receive character queues of a UART and turns their fill levels into request lines for an external DMA controller. The DMA engine writes 8-bit characters into the transmit queue, and the serializer drains it. The deserializer fills the receive queue with 12-bit entries, each made of 8 data bits plus 4 error flags, and the DMA engine reads them out.

Each direction has two request lines that are driven independently of each other. The single-transfer request tells the engine that at least one character can move. The burst-transfer request tells it that a block at least as large as the programmed threshold can move. Both lines can be high in the same cycle. When the engine finishes a transfer, it sends a one-cycle clear pulse for that direction. A configuration input shrinks both queues to a one-entry holding register. In that mode only single transfers are requested.

The request lines are registered. A FIFO write or read changes the occupancy at the clock edge where it is accepted, and the request lines follow that occupancy one clock edge later.

Top module: `uart_dma_req_gen`

## Requirements
- R1: After reset, all four request outputs are low, `tx_valid` is low and both queues are empty.
- R2: While transmit DMA is enabled, `tx_sreq` is high exactly when the transmit queue has at least one free slot. It is low while the queue is full. It follows the occupancy one clock edge after the occupancy changes.
- R3: In queue mode, with transmit DMA enabled, `tx_breq` is high exactly when the number of free transmit slots is greater than or equal to the transmit threshold.
- R4: While receive DMA is enabled, `rx_sreq` is high exactly when the receive queue holds at least one entry.
- R5: In queue mode, with receive DMA enabled, `rx_breq` is high exactly when the receive occupancy is greater than or equal to the receive threshold. `rx_sreq` is also high whenever `rx_breq` is high.
- R6: The 3-bit threshold selects map to levels of the 16-entry queue as follows: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, 4 gives 14, and 5 to 7 give 8.
- R7: When `cfg_fifo_en` is 0, each queue holds one entry. A second write is dropped, and both burst outputs stay low.
- R8: When `cfg_tx_dma_en` is 0, both transmit requests stay low. When `cfg_rx_dma_en` is 0, both receive requests stay low.
- R9: A one-cycle pulse on `tx_clr` or `rx_clr` forces both requests of that direction low in the following cycle. One cycle after that, the requests again reflect the current occupancy, including any write that was accepted in the same cycle as the pulse.
- R10: When `cfg_rx_err_hold` is 1 and the head receive entry has any of bits [11:8] set, both receive requests are low.
- R11: A write to a full transmit queue is ignored, and so is a read from an empty receive queue. Entries leave each queue in write order, and all 12 bits of a receive entry are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_en | input | 1 | 1: 16-entry queues, 0: one-entry holding registers |
| cfg_tx_dma_en | input | 1 | Transmit DMA enable |
| cfg_rx_dma_en | input | 1 | Receive DMA enable |
| cfg_rx_err_hold | input | 1 | Hold receive requests while the head entry has error flags |
| cfg_tx_wm | input | 3 | Transmit threshold select |
| cfg_rx_wm | input | 3 | Receive threshold select |
| tx_wr | input | 1 | Push a character into the transmit queue |
| tx_wdata | input | 8 | Transmit character |
| tx_rd | input | 1 | Serializer pops the transmit head |
| tx_rdata | output | 8 | Transmit head character |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_wr | input | 1 | Deserializer pushes a receive entry |
| rx_wdata | input | 12 | Receive entry: flags [11:8], data [7:0] |
| rx_rd | input | 1 | DMA pops the receive head |
| rx_rdata | output | 12 | Receive head entry |
| tx_sreq | output | 1 | Transmit single-transfer request |
| tx_breq | output | 1 | Transmit burst-transfer request |
| tx_clr | input | 1 | Transmit request clear pulse |
| rx_sreq | output | 1 | Receive single-transfer request |
| rx_breq | output | 1 | Receive burst-transfer request |
| rx_clr | input | 1 | Receive request clear pulse |

## Verification
The clear pulse and an occupancy change can land on the same edge. The bench provokes this by raising `rx_clr` together with an `rx_wr` that lifts the receive occupancy from one below the threshold to exactly the threshold. It then checks that both receive requests are low in the next cycle and that both are high in the cycle after, which shows that the clear did not swallow the write. The single and burst lines are also judged together at every threshold crossing, because both can switch on the same edge.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

   localparam int unsigned CHAR_W = 8;
   localparam int unsigned FLAG_W = 4;
   localparam int unsigned RXE_W  = CHAR_W + FLAG_W;

   typedef enum logic [2:0] {
      WM_EIGHTH   = 3'd0,
      WM_QUARTER  = 3'd1,
      WM_HALF     = 3'd2,
      WM_3QUARTER = 3'd3,
      WM_7EIGHTH  = 3'd4
   } wm_sel_e;

endpackage

// File: rtl/udr_fifo.sv
module udr_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic [CNT_W-1:0] level,
   output logic [CNT_W-1:0] free,
   output logic             not_empty
);

   localparam logic [CNT_W-1:0] FULL_CAP = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_CAP  = CNT_W'(1);

   if (DEPTH < 8) begin : g_bad_depth
      $error("udr_fifo: DEPTH must be at least 8");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("udr_fifo: DEPTH must be a power of two");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("udr_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cap;
   logic             full, wr_ok, rd_ok;

   assign cap       = fifo_en ? FULL_CAP : ONE_CAP;
   assign full      = (level >= cap);
   assign not_empty = (level != '0);
   assign free      = full ? '0 : (cap - level);
   assign wr_ok     = wr && !full;
   assign rd_ok     = rd && not_empty;
   assign rdata     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (wr_ok) begin
            wr_ptr <= wr_ptr + AW'(1);
         end
         if (rd_ok) begin
            rd_ptr <= rd_ptr + AW'(1);
         end
         case ({wr_ok, rd_ok})
            2'b10:   level <= level + CNT_W'(1);
            2'b01:   level <= level - CNT_W'(1);
            default: level <= level;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_CAP); // R11
   AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rd && free == '0) |=> (level == $past(level))); // R11
   AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr && level == '0) |=> (level == '0)); // R11

endmodule

// File: rtl/udr_wm_decode.sv
module udr_wm_decode
   import uart_dma_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [2:0]       sel,
   output logic [CNT_W-1:0] wm
);

   localparam logic [CNT_W-1:0] LV_EIGHTH   = CNT_W'(DEPTH / 8);
   localparam logic [CNT_W-1:0] LV_QUARTER  = CNT_W'(DEPTH / 4);
   localparam logic [CNT_W-1:0] LV_HALF     = CNT_W'(DEPTH / 2);
   localparam logic [CNT_W-1:0] LV_3QUARTER = CNT_W'((DEPTH * 3) / 4);
   localparam logic [CNT_W-1:0] LV_7EIGHTH  = CNT_W'((DEPTH * 7) / 8);

   if (DEPTH / 8 < 1) begin : g_bad_depth
      $error("udr_wm_decode: smallest threshold would be zero");
   end

   always_comb begin
      case (sel)
         WM_EIGHTH:   wm = LV_EIGHTH;
         WM_QUARTER:  wm = LV_QUARTER;
         WM_HALF:     wm = LV_HALF;
         WM_3QUARTER: wm = LV_3QUARTER;
         WM_7EIGHTH:  wm = LV_7EIGHTH;
         default:     wm = LV_HALF;
      endcase
   end

   AST_WM_NONZERO: assert final (wm != '0); // R6

endmodule

// File: rtl/udr_req_ctrl.sv
module udr_req_ctrl #(
   parameter int unsigned DEPTH = 16,
   parameter bit          IS_TX = 1'b1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_en,
   input  logic             fifo_en,
   input  logic             clr,
   input  logic             hold,
   input  logic [CNT_W-1:0] fill,
   input  logic [CNT_W-1:0] free,
   input  logic [CNT_W-1:0] wm,
   output logic             sreq,
   output logic             breq
);

   logic single_c, burst_c, quiet;

   if (IS_TX) begin : g_tx_metric
      assign single_c = (free != '0);
      assign burst_c  = (free >= wm);
   end else begin : g_rx_metric
      assign single_c = (fill != '0);
      assign burst_c  = (fill >= wm);
   end

   assign quiet = clr || !dir_en || hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreq <= 1'b0;
         breq <= 1'b0;
      end else if (quiet) begin
         sreq <= 1'b0;
         breq <= 1'b0;
      end else begin
         sreq <= single_c;
         breq <= burst_c && fifo_en;
      end
   end

   AST_BURST_WITH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      breq |-> sreq); // R5
   AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!sreq && !breq)); // R9
   AST_NOFIFO_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> !breq); // R7
   AST_DIR_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_en |=> (!sreq && !breq)); // R8

endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen
   import uart_dma_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_fifo_en,
   input  logic              cfg_tx_dma_en,
   input  logic              cfg_rx_dma_en,
   input  logic              cfg_rx_err_hold,
   input  logic [2:0]        cfg_tx_wm,
   input  logic [2:0]        cfg_rx_wm,
   input  logic              tx_wr,
   input  logic [CHAR_W-1:0] tx_wdata,
   input  logic              tx_rd,
   output logic [CHAR_W-1:0] tx_rdata,
   output logic              tx_valid,
   input  logic              rx_wr,
   input  logic [RXE_W-1:0]  rx_wdata,
   input  logic              rx_rd,
   output logic [RXE_W-1:0]  rx_rdata,
   output logic              tx_sreq,
   output logic              tx_breq,
   input  logic              tx_clr,
   output logic              rx_sreq,
   output logic              rx_breq,
   input  logic              rx_clr
);

   logic [CNT_W-1:0] tx_fill, tx_free, rx_fill, rx_free;
   logic [CNT_W-1:0] tx_wm_lv, rx_wm_lv;
   logic             rx_nonempty, rx_hold;

   udr_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
      .wr(tx_wr), .wdata(tx_wdata), .rd(tx_rd), .rdata(tx_rdata),
      .level(tx_fill), .free(tx_free), .not_empty(tx_valid));

   udr_fifo #(.WIDTH(RXE_W), .DEPTH(DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
      .wr(rx_wr), .wdata(rx_wdata), .rd(rx_rd), .rdata(rx_rdata),
      .level(rx_fill), .free(rx_free), .not_empty(rx_nonempty));

   udr_wm_decode #(.DEPTH(DEPTH)) u_tx_wm (.sel(cfg_tx_wm), .wm(tx_wm_lv));
   udr_wm_decode #(.DEPTH(DEPTH)) u_rx_wm (.sel(cfg_rx_wm), .wm(rx_wm_lv));

   assign rx_hold = cfg_rx_err_hold && rx_nonempty && (|rx_rdata[RXE_W-1:CHAR_W]);

   udr_req_ctrl #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_req (
      .clk(clk), .rst_n(rst_n), .dir_en(cfg_tx_dma_en), .fifo_en(cfg_fifo_en),
      .clr(tx_clr), .hold(1'b0), .fill(tx_fill), .free(tx_free), .wm(tx_wm_lv),
      .sreq(tx_sreq), .breq(tx_breq));

   udr_req_ctrl #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_req (
      .clk(clk), .rst_n(rst_n), .dir_en(cfg_rx_dma_en), .fifo_en(cfg_fifo_en),
      .clr(rx_clr), .hold(rx_hold), .fill(rx_fill), .free(rx_free), .wm(rx_wm_lv),
      .sreq(rx_sreq), .breq(rx_breq));

   AST_ERR_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hold |=> (!rx_sreq && !rx_breq)); // R10
   AST_TX_FULL_NO_SREQ: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free == '0) |=> !tx_sreq); // R2
   AST_RX_EMPTY_NO_SREQ: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_nonempty |=> !rx_sreq); // R4

endmodule

// File: tb/uart_dma_req_gen_bench.sv
`timescale 1ns/1ps
module uart_dma_req_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_fifo_en = 1'b0, cfg_tx_dma_en = 1'b0, cfg_rx_dma_en = 1'b0;
   logic        cfg_rx_err_hold = 1'b0;
   logic [2:0]  cfg_tx_wm = 3'd0, cfg_rx_wm = 3'd0;
   logic        tx_wr = 1'b0, tx_rd = 1'b0, rx_wr = 1'b0, rx_rd = 1'b0;
   logic [7:0]  tx_wdata = '0;
   logic [11:0] rx_wdata = '0;
   logic        tx_clr = 1'b0, rx_clr = 1'b0;
   logic [7:0]  tx_rdata;
   logic [11:0] rx_rdata;
   logic        tx_valid, tx_sreq, tx_breq, rx_sreq, rx_breq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_dma_req_gen u_uart_dma_req_gen (
      .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en),
      .cfg_tx_dma_en(cfg_tx_dma_en), .cfg_rx_dma_en(cfg_rx_dma_en),
      .cfg_rx_err_hold(cfg_rx_err_hold), .cfg_tx_wm(cfg_tx_wm), .cfg_rx_wm(cfg_rx_wm),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd), .tx_rdata(tx_rdata),
      .tx_valid(tx_valid), .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_rd(rx_rd),
      .rx_rdata(rx_rdata), .tx_sreq(tx_sreq), .tx_breq(tx_breq), .tx_clr(tx_clr),
      .rx_sreq(rx_sreq), .rx_breq(rx_breq), .rx_clr(rx_clr));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_tx(logic [7:0] d);
      tx_wr = 1'b1; tx_wdata = d; step(1); tx_wr = 1'b0;
   endtask

   task automatic pop_tx(logic [7:0] exp, string tag);
      chk(tag, {24'h0, tx_rdata}, {24'h0, exp});
      tx_rd = 1'b1; step(1); tx_rd = 1'b0;
   endtask

   task automatic push_rx(logic [11:0] d);
      rx_wr = 1'b1; rx_wdata = d; step(1); rx_wr = 1'b0;
   endtask

   task automatic pop_rx(logic [11:0] exp, string tag);
      chk(tag, {20'h0, rx_rdata}, {20'h0, exp});
      rx_rd = 1'b1; step(1); rx_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 tx_sreq", tx_sreq, 0); chk("R1 tx_breq", tx_breq, 0);
      chk("R1 rx_sreq", rx_sreq, 0); chk("R1 rx_breq", rx_breq, 0);
      chk("R1 tx_valid", tx_valid, 0);
   endtask

   task automatic t_tx_levels();
      cfg_fifo_en = 1; cfg_tx_dma_en = 1; cfg_rx_dma_en = 1;
      cfg_tx_wm = 3'd2; cfg_rx_wm = 3'd2; step(2);
      chk("R2 empty tx sreq", tx_sreq, 1); chk("R3 empty tx breq", tx_breq, 1);
      chk("R4 empty rx sreq", rx_sreq, 0);
      for (int i = 0; i < 8; i++) push_tx(8'h10 + 8'(i));
      step(1); chk("R3 free=8 breq", tx_breq, 1);
      push_tx(8'h18); step(1);
      chk("R3 free=7 breq", tx_breq, 0); chk("R2 free=7 sreq", tx_sreq, 1);
      for (int i = 9; i < 16; i++) push_tx(8'h10 + 8'(i));
      step(1); chk("R2 full sreq", tx_sreq, 0);
      push_tx(8'hEE); step(1); chk("R2 full after drop", tx_sreq, 0);
      for (int i = 0; i < 16; i++) pop_tx(8'h10 + 8'(i), "R11 tx order");
      chk("R11 tx drained", tx_valid, 0);
      step(1); chk("R2 refilled sreq", tx_sreq, 1); chk("R3 refilled breq", tx_breq, 1);
   endtask

   task automatic t_rx_levels();
      push_rx(12'h0A0); step(1);
      chk("R4 one entry sreq", rx_sreq, 1); chk("R5 one entry breq", rx_breq, 0);
      for (int i = 1; i < 8; i++) push_rx(12'h0A0 + 12'(i));
      step(1); chk("R5 at wm breq", rx_breq, 1); chk("R5 at wm sreq", rx_sreq, 1);
      for (int i = 8; i < 12; i++) push_rx(12'h0A0 + 12'(i));
      for (int s = 0; s < 8; s++) begin
         cfg_rx_wm = 3'(s); step(1);
         chk($sformatf("R6 sel=%0d at 12", s), rx_breq, (s == 4) ? 0 : 1);
      end
      cfg_rx_wm = 3'd2; step(1);
   endtask

   task automatic t_clear_with_write();
      for (int i = 0; i < 5; i++) pop_rx(12'h0A0 + 12'(i), "R11 rx order");
      step(1); chk("R5 below wm breq", rx_breq, 0); chk("R5 below wm sreq", rx_sreq, 1);
      rx_clr = 1; rx_wr = 1; rx_wdata = 12'h0B0; step(1); rx_clr = 0; rx_wr = 0;
      chk("R9 cleared sreq", rx_sreq, 0); chk("R9 cleared breq", rx_breq, 0);
      step(1);
      chk("R9 reeval sreq", rx_sreq, 1); chk("R9 reeval breq", rx_breq, 1);
      tx_clr = 1; step(1); tx_clr = 0;
      chk("R9 tx cleared", tx_sreq, 0);
      step(1); chk("R9 tx reeval", tx_sreq, 1);
   endtask

   task automatic t_rx_drain();
      for (int i = 5; i < 12; i++) pop_rx(12'h0A0 + 12'(i), "R11 rx order");
      pop_rx(12'h0B0, "R11 rx order tail");
      rx_rd = 1; step(1); rx_rd = 0;
      step(1); chk("R4 empty sreq", rx_sreq, 0);
      push_rx(12'hFC3); step(1);
      chk("R11 empty read ignored", {20'h0, rx_rdata}, 32'hFC3);
      chk("R4 after refill sreq", rx_sreq, 1);
      rx_rd = 1; step(1); rx_rd = 0;
   endtask

   task automatic t_err_hold();
      cfg_rx_err_hold = 1;
      push_rx(12'h555); push_rx(12'h066); step(1);
      chk("R10 held sreq", rx_sreq, 0); chk("R10 held breq", rx_breq, 0);
      cfg_rx_err_hold = 0; step(1); chk("R10 unmasked sreq", rx_sreq, 1);
      cfg_rx_err_hold = 1; step(1); chk("R10 remasked sreq", rx_sreq, 0);
      pop_rx(12'h555, "R11 flags kept"); step(1);
      chk("R10 clean head sreq", rx_sreq, 1);
      pop_rx(12'h066, "R11 rx order"); cfg_rx_err_hold = 0; step(1);
   endtask

   task automatic t_no_fifo();
      cfg_fifo_en = 0; step(1);
      chk("R7 tx sreq", tx_sreq, 1); chk("R7 tx breq", tx_breq, 0);
      push_tx(8'h5A); step(1); chk("R7 tx one full", tx_sreq, 0);
      push_tx(8'hA5); pop_tx(8'h5A, "R7 tx holding");
      chk("R7 tx second dropped", tx_valid, 0);
      push_rx(12'h123); step(1);
      chk("R7 rx sreq", rx_sreq, 1); chk("R7 rx breq", rx_breq, 0);
      push_rx(12'h321); pop_rx(12'h123, "R7 rx holding"); step(1);
      chk("R7 rx second dropped", rx_sreq, 0);
      cfg_fifo_en = 1; step(1);
   endtask

   task automatic t_disable();
      cfg_tx_dma_en = 0; step(1);
      chk("R8 tx off sreq", tx_sreq, 0); chk("R8 tx off breq", tx_breq, 0);
      push_rx(12'h011); cfg_rx_dma_en = 0; step(1);
      chk("R8 rx off sreq", rx_sreq, 0);
      cfg_rx_dma_en = 1; step(1); chk("R8 rx back on", rx_sreq, 1);
      cfg_tx_dma_en = 1; step(1); chk("R8 tx back on", tx_sreq, 1);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      step(3); rst_n = 1'b1; step(1);
      t_reset();
      t_tx_levels();
      t_rx_levels();
      t_clear_with_write();
      t_rx_drain();
      t_err_hold();
      t_no_fifo();
      t_disable();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

endmodule